// File: doc/BRIEF.md
# Dual Output Clock Divider Bank

This block divides one fast source clock into two separate slower clocks. Each output has its own 2-bit select. The select either disables that output or picks a divide ratio of 4, 8 or 32. From a 622.08 MHz source, the three ratios give 155.52, 77.76 and 19.44 MHz. A disabled output drops its enable flag so that a three-state pad driver further out can float the pin, and the clock bit itself is parked low.

Both outputs are taps of a single free-running 5-bit counter, so every ratio has an exact 50 % duty cycle. Outputs set to the same code produce the same waveform, edge for edge. A new select value is captured only when the counter wraps from 31 to 0. At that point every tap is low, so a change of ratio never produces a runt pulse. Out of reset both outputs are disabled until the first wrap.

Top module: `clkdiv_pair`

## Requirements
- R1: While reset is low and on release, out_a, out_b, oe_a and oe_b are all 0. Both outputs stay disabled until the counter wraps for the first time, 32 source cycles after release.
- R2: Code 2'b00 drives the enable flag of that output to 0 and holds its clock output at 0.
- R3: Code 2'b01 sets the enable flag to 1 and gives a clock whose period is 32 source cycles, high for 16 of them.
- R4: Code 2'b10 sets the enable flag to 1 and gives a clock whose period is 8 source cycles, high for 4 of them.
- R5: Code 2'b11 sets the enable flag to 1 and gives a clock whose period is 4 source cycles, high for 2 of them.
- R6: The two outputs are independent, each following only its own select. When both active codes are equal, out_a and out_b are identical in every cycle.
- R7: The select is captured only on the edge at which the counter goes from 31 to 0. Changes to the select between wraps have no effect on the clock or the enable flag until that edge.
- R8: After a wrap, every enabled output starts low and first rises after half its period. Counter value k, counted from that wrap, shows bit (log2 ratio - 1) of k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 2 | Select for output A: 00 off, 01 /32, 10 /8, 11 /4 |
| sel_b | input | 2 | Select for output B, same encoding |
| out_a | output | 1 | Divided clock A |
| oe_a | output | 1 | Output enable for A, low selects high impedance |
| out_b | output | 1 | Divided clock B |
| oe_b | output | 1 | Output enable for B |

## Verification
Every code pair is applied: each code on A against a different code on B, and equal codes on both. The rise count over a 64-cycle window tells the three ratios apart. The high count confirms the 50 % duty, and a per-cycle comparison shows that equal codes are edge-aligned while unequal codes do not disturb each other. A select change in the middle of a span shows whether the ratio and the enable flag hold until the wrap. Sampling at set counter phases after the wrap shows whether the new ratio starts in the low half.

// File: rtl/clkdiv_pair.sv
module clkdiv_pair #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  output logic       out_a,
  output logic       oe_a,
  output logic       out_b,
  output logic       oe_b
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [1:0]       code_a, code_b, code_a_nx, code_b_nx;
  logic             wrap;

  function automatic logic tap(input logic [1:0] c, input logic [CNT_W-1:0] v);
    case (c)
      2'b01:   tap = v[CNT_W-1];
      2'b10:   tap = v[2];
      2'b11:   tap = v[1];
      default: tap = 1'b0;
    endcase
  endfunction

  assign wrap      = (cnt == LAST);
  assign cnt_nx    = cnt + 1'b1;
  assign code_a_nx = wrap ? sel_a : code_a;
  assign code_b_nx = wrap ? sel_b : code_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      code_a <= 2'b00;
      code_b <= 2'b00;
      out_a  <= 1'b0;
      out_b  <= 1'b0;
      oe_a   <= 1'b0;
      oe_b   <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      code_a <= code_a_nx;
      code_b <= code_b_nx;
      out_a  <= tap(code_a_nx, cnt_nx);
      out_b  <= tap(code_b_nx, cnt_nx);
      oe_a   <= |code_a_nx;
      oe_b   <= |code_b_nx;
    end
  end
endmodule

// File: rtl/clkdiv_pair_chk.sv
module clkdiv_pair_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       code_a,
  input logic [1:0]       code_b,
  input logic             out_a,
  input logic             out_b,
  input logic             oe_a,
  input logic             oe_b
);
  p_parked_low_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_a |-> !out_a);
  p_parked_low_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_b |-> !out_b);
  p_enable_at_wrap_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a != $past(oe_a)) |-> (cnt == '0));
  p_enable_at_wrap_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b != $past(oe_b)) |-> (cnt == '0));
  p_quarter_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a == 2'b11 && $past(code_a) == 2'b11 && $past(code_a, 2) == 2'b11)
      |-> (out_a != $past(out_a, 2)));
  p_equal_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a == code_b) |-> (out_a == out_b));
  p_wrap_starts_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (!out_a && !out_b));
endmodule

bind clkdiv_pair clkdiv_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .code_a(code_a), .code_b(code_b),
  .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .oe_b(oe_b)
);

// File: tb/sim_clkdiv_pair.sv
`timescale 1ns/1ps
module sim_clkdiv_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel_a = 2'b00, sel_b = 2'b00;
  logic out_a, oe_a, out_b, oe_b;

  int n_chk = 0, n_fail = 0;
  int phase = 0;

  typedef struct { logic [1:0] ca; logic [1:0] cb; } item_t;
  item_t q[$];
  event done;

  clkdiv_pair u0 (.clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
                  .out_a(out_a), .oe_a(oe_a), .out_b(out_b), .oe_b(oe_b));

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) phase <= (phase + 1) % 32;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rises_for(input logic [1:0] c);
    case (c) 2'b01: return 2; 2'b10: return 8; 2'b11: return 16; default: return 0; endcase
  endfunction

  function automatic string req_for(input logic [1:0] c);
    case (c) 2'b01: return "R3"; 2'b10: return "R4"; 2'b11: return "R5"; default: return "R2"; endcase
  endfunction

  task automatic wait_phase(input int p);
    @(negedge clk);
    while (phase != p) @(negedge clk);
  endtask

  // driver: apply codes, let them pass a wrap, hand the expectation to the monitor
  task automatic drive(input logic [1:0] a, input logic [1:0] b);
    item_t it;
    @(negedge clk);
    sel_a = a; sel_b = b;
    wait_phase(1);
    it.ca = a; it.cb = b;
    q.push_back(it);
    @(done);
  endtask

  // monitor: measures 64 cycles per queued item
  initial begin
    forever begin
      item_t it;
      int ra, rb, ha, hb, diff, ea, eb;
      logic pa, pb;
      wait (q.size() > 0);
      it = q.pop_front();
      ra = 0; rb = 0; ha = 0; hb = 0; diff = 0; ea = 0; eb = 0;
      pa = out_a; pb = out_b;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (out_a && !pa) ra++;
        if (out_b && !pb) rb++;
        ha += out_a; hb += out_b; ea += oe_a; eb += oe_b;
        if (out_a != out_b) diff++;
        pa = out_a; pb = out_b;
      end
      check(req_for(it.ca), "A rises", ra, rises_for(it.ca));
      check(req_for(it.cb), "B rises", rb, rises_for(it.cb));
      check(req_for(it.ca), "A high cycles", ha, (it.ca == 2'b00) ? 0 : 32);
      check(req_for(it.cb), "B high cycles", hb, (it.cb == 2'b00) ? 0 : 32);
      check(req_for(it.ca), "A enable cycles", ea, (it.ca == 2'b00) ? 0 : 64);
      check(req_for(it.cb), "B enable cycles", eb, (it.cb == 2'b00) ? 0 : 64);
      if (it.ca == it.cb) check("R6", "equal-code mismatches", diff, 0);
      else if (it.ca != 2'b00 || it.cb != 2'b00) check("R6", "distinct codes differ", int'(diff > 0), 1);
      -> done;
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "out_a in reset", out_a, 0);
    check("R1", "oe_a in reset", oe_a, 0);
    check("R1", "oe_b in reset", oe_b, 0);
    sel_a = 2'b11; sel_b = 2'b01;
    rst_n = 1'b1;
    wait_phase(20);
    check("R1", "oe_a before first wrap", oe_a, 0);
    check("R1", "out_b before first wrap", out_b, 0);

    drive(2'b01, 2'b11);
    drive(2'b10, 2'b00);
    drive(2'b11, 2'b10);
    drive(2'b00, 2'b01);
    drive(2'b01, 2'b01);
    drive(2'b10, 2'b10);
    drive(2'b11, 2'b11);
    drive(2'b00, 2'b00);

    // R7: mid-span change from /32 to /4 waits for the wrap
    drive(2'b01, 2'b00);
    wait_phase(5);
    sel_a = 2'b11;
    wait_phase(10);
    check("R7", "A still /32 low at phase 10", out_a, 0);
    wait_phase(20);
    check("R7", "A still /32 high at phase 20", out_a, 1);
    // R8: after the wrap /4 starts low, rises at phase 2
    wait_phase(0);
    check("R8", "A low at wrap", out_a, 0);
    wait_phase(1);
    check("R8", "A low at phase 1", out_a, 0);
    wait_phase(2);
    check("R8", "A high at phase 2", out_a, 1);
    // R7: disable request mid-span keeps enable until the wrap
    wait_phase(6);
    sel_a = 2'b00;
    wait_phase(30);
    check("R7", "A enable held before wrap", oe_a, 1);
    check("R7", "A still /4 at phase 30", out_a, 1);
    wait_phase(0);
    check("R2", "A disabled after wrap", oe_a, 0);
    wait_phase(2);
    check("R2", "A parked low", out_a, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule